// File: doc/BRIEF.md
# Address-Matched Serial Attenuation Loader

This block turns a slow three-wire serial programming stream into the 7-bit control word that drives the binary-weighted stages of a step attenuator. A 16-bit frame is shifted in, least significant bit first. The attenuation byte arrives first and the address byte follows it. When the latch-enable line rises, the block compares the low three address bits in the frame against three strapped address pins. It copies the 7-bit code to its output only if they match. Up to eight such loaders can therefore share one data, clock and latch line, each strapped to a different address.

The serial lines are asynchronous to the system clock. They are synchronized with a two-flop chain, and their rising edges are detected in the system clock domain. Each code step is a quarter decibel, so the code equals the wanted attenuation in dB times four. After reset the output holds the maximum attenuation. The loader acts only while the serial/parallel select is high.

Top module: `serial_attn_loader`

## Requirements
- R1: While reset is asserted, and after it until the first accepted frame, `atten_code` is all ones (127, the 31.75 dB state).
- R2: Bits are shifted in least significant first on each rising `ser_clk` seen while `ser_le` is low. After 16 shifts, frame bit 15 is the last bit sent. Frame bits 6..0 carry the attenuation code and bits 15..8 carry the address byte.
- R3: On a rising `ser_le`, if frame bits 10..8 equal `addr_strap`, `atten_code` takes frame bits 6..0 within a few system clocks.
- R4: On a rising `ser_le` whose frame bits 10..8 differ from `addr_strap`, `atten_code` keeps its previous value.
- R5: Frame bits 15..11 and bit 7 have no effect on the comparison or on the loaded code.
- R6: `atten_code` does not change while a frame is being shifted. It changes only after a rising `ser_le`.
- R7: Rising `ser_clk` edges while `ser_le` is high do not shift. Re-latching afterwards reloads the same frame.
- R8: When more than 16 clocks are sent before the latch, only the last 16 bits sent form the frame.
- R9: While `ser_mode` is low, neither shifting nor loading takes place. The frame register and `atten_code` are left untouched.
- R10: The code is the attenuation in dB times four. For example, 9.5 dB is loaded as code 38 and 18.25 dB as code 73.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 selects the serial programming path |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_le | input | 1 | Latch enable, asynchronous |
| addr_strap | input | 3 | Static device address |
| atten_code | output | 7 | Attenuation control word, 0.25 dB per LSB |

## Verification
The bench sweeps every 7-bit code at one address and every frame/strap address pair. A swapped bit order, a wrong address slice or an update on mismatch would show up there as wrong codes. It fills the don't-care bits with changing patterns, so a compare that reads the upper address bits would drop valid frames. Overlong frames catch a register that keeps the first bits instead of the last. Clock pulses sent while the latch line is high, followed by a re-latch, expose a shifter that ignores the latch level. A frame sent in parallel mode, followed by a bare latch pulse, shows whether the mode gate was missed.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int unsigned DEF_WORD_W   = 8;
  localparam int unsigned DEF_CODE_W   = 7;
  localparam int unsigned DEF_ADDR_W   = 3;
  localparam int unsigned DEF_SYNC_LEN = 2;

  // control lines after synchronization, packed as one vector
  typedef struct packed {
    logic le;
    logic sck;
    logic sdi;
  } ser_lines_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] frame
);
  // new bit enters at the top, so the first bit sent ends at bit 0
  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {din, frame[W-1:1]};
  end
endmodule

// File: rtl/atten_latch.sv
module atten_latch #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] addr_strap,
  output logic [CODE_W-1:0] code_out
);
  logic hit;
  assign hit = (addr_in == addr_strap);

  always_ff @(posedge clk) begin
    if (rst)              code_out <= '1;
    else if (load && hit) code_out <= code_in;
  end
endmodule

// File: rtl/serial_attn_loader.sv
module serial_attn_loader
  import attn_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_le,
  input  logic [ADDR_W-1:0] addr_strap,
  output logic [CODE_W-1:0] atten_code
);
  localparam int unsigned FRAME_W  = 2 * WORD_W;
  localparam int unsigned ADDR_LSB = WORD_W;

  ser_lines_t lines_s;
  logic       sck_d, le_d;
  logic       sck_rise, le_rise;
  logic       shift_en, load;
  logic [FRAME_W-1:0] frame;

  serial_sync #(.W($bits(ser_lines_t)), .STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ser_le, ser_clk, ser_data}),
    .dout (lines_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      sck_d <= lines_s.sck;
      le_d  <= lines_s.le;
    end
  end

  assign sck_rise = lines_s.sck & ~sck_d;
  assign le_rise  = lines_s.le & ~le_d;
  assign shift_en = ser_mode & sck_rise & ~lines_s.le;
  assign load     = ser_mode & le_rise;

  frame_shift #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (lines_s.sdi),
    .frame    (frame)
  );

  atten_latch #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .code_in    (frame[CODE_W-1:0]),
    .addr_in    (frame[ADDR_LSB +: ADDR_W]),
    .addr_strap (addr_strap),
    .code_out   (atten_code)
  );
endmodule

// File: rtl/attn_loader_chk.sv
module attn_loader_chk #(
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned ADDR_LSB = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ser_mode,
  input logic               le_lvl,
  input logic               le_rise,
  input logic [ADDR_W-1:0]  addr_strap,
  input logic [FRAME_W-1:0] frame,
  input logic [CODE_W-1:0]  atten_code
);
  logic match;
  assign match = (frame[ADDR_LSB +: ADDR_W] == addr_strap);

  a_r1_reset_max: assert property (@(posedge clk)
    rst |=> (atten_code == {CODE_W{1'b1}}));

  a_r6_no_change_without_latch: assert property (@(posedge clk) disable iff (rst)
    !(ser_mode && le_rise) |=> $stable(atten_code));

  a_r3_match_loads: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && le_rise && match) |=> (atten_code == $past(frame[CODE_W-1:0])));

  a_r4_mismatch_holds: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && le_rise && !match) |=> $stable(atten_code));

  a_r7_no_shift_le_high: assert property (@(posedge clk) disable iff (rst)
    le_lvl |=> $stable(frame));

  a_r9_parallel_quiet: assert property (@(posedge clk) disable iff (rst)
    !ser_mode |=> ($stable(frame) && $stable(atten_code)));
endmodule

bind serial_attn_loader attn_loader_chk #(
  .FRAME_W  (FRAME_W),
  .CODE_W   (CODE_W),
  .ADDR_W   (ADDR_W),
  .ADDR_LSB (ADDR_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ser_mode   (ser_mode),
  .le_lvl     (lines_s.le),
  .le_rise    (le_rise),
  .addr_strap (addr_strap),
  .frame      (frame),
  .atten_code (atten_code)
);

// File: tb/tb_serial_attn_loader.sv
module tb_serial_attn_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b1;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_le = 1'b0;
  logic [2:0] addr_strap = 3'd0;
  logic [6:0] atten_code;

  int total = 0;
  int bad = 0;
  logic [6:0] exp_code;

  always #5 clk = ~clk;

  serial_attn_loader dut (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_le(ser_le), .addr_strap(addr_strap),
    .atten_code(atten_code)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put_bit(input logic b);
    ser_data = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
  endtask

  // sends n bits, bit 0 first
  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) put_bit(bits[i]);
    wait_cyc(4);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_cyc(8);
    ser_le = 1'b0;
    wait_cyc(6);
  endtask

  // full frame, model update from R3/R4 rule
  task automatic frame_go(input logic [7:0] abyte, input logic [7:0] dbyte, input string tag);
    send_bits({16'h0, abyte, dbyte}, 16);
    check({tag, " R6 held during shift"}, atten_code, exp_code);
    if (abyte[2:0] == addr_strap) exp_code = dbyte[6:0];
    pulse_le();
    check(tag, atten_code, exp_code);
  endtask

  initial begin : watchdog
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    wait_cyc(5);
    check("R1 in reset", atten_code, 7'h7F);
    rst = 1'b0;
    wait_cyc(5);
    exp_code = 7'h7F;
    check("R1 after reset", atten_code, exp_code);

    // R2/R3/R5: every code at address 5, don't-care bits varied
    addr_strap = 3'd5;
    for (int c = 0; c < 128; c++) begin
      logic [7:0] ab, db;
      ab = {5'(c * 7), 3'd5};
      db = {c[2], 7'(c)};
      frame_go(ab, db, "R2 R3 R5 code sweep");
    end

    // R3/R4: every strap/frame address pair
    for (int p = 0; p < 8; p++) begin
      addr_strap = 3'(p);
      for (int a = 0; a < 8; a++) begin
        logic [7:0] ab, db;
        ab = {5'(a * 3 + p), 3'(a)};
        db = {1'b1, 7'((p * 8 + a) ^ 7'h2A)};
        frame_go(ab, db, (a == p) ? "R3 address match" : "R4 address mismatch");
      end
    end

    // R10: dB times four
    addr_strap = 3'd3;
    frame_go({5'd0, 3'd3}, 8'd38, "R10 9.5dB");
    check("R10 9.5dB value", atten_code, 7'd38);
    frame_go({5'h1F, 3'd3}, 8'd73, "R10 18.25dB");
    check("R10 18.25dB value", atten_code, 7'd73);

    // R8: 24 clocks, the last 16 form the frame
    addr_strap = 3'd2;
    send_bits({8'h0, 8'h02, 8'h15, 8'hFF}, 24);
    pulse_le();
    check("R8 overlong frame", atten_code, 7'h15);
    exp_code = 7'h15;

    // R7: clocks during LE high must not shift
    addr_strap = 3'd7;
    frame_go(8'hFF, 8'h11, "R7 setup");
    ser_le = 1'b1;
    wait_cyc(8);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    ser_le = 1'b0;
    wait_cyc(6);
    check("R7 no change after clocks with LE high", atten_code, 7'h11);
    pulse_le();
    check("R7 relatch keeps frame", atten_code, 7'h11);

    // R9: parallel mode, no shift and no load
    ser_mode = 1'b0;
    send_bits({16'h0, 8'h07, 8'h4C}, 16);
    pulse_le();
    check("R9 no load in parallel mode", atten_code, 7'h11);
    ser_mode = 1'b1;
    wait_cyc(4);
    pulse_le();
    check("R9 frame untouched in parallel mode", atten_code, 7'h11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule